// File: doc/BRIEF.md
# Audio Clock Generator and Speed Detector

This block produces the serial audio clocks for a stereo PCM input stage from one high-frequency clock that an outside phase-locked loop supplies. When it is the clock master, it divides that clock into three outputs: a master clock, a bit clock at 64 times the sample rate, and a frame clock at the sample rate. The division ratios follow the selected speed (normal, double or quad), so the frame clock always runs at the sample rate. The high-frequency clock is 2048, 1024 or 512 times the sample rate in those three speeds.

When it is a clock slave, the master, bit and frame outputs stay low and the external clocks are used instead. The block samples the external master clock and frame clock in its own clock domain. It counts master-clock rising edges between frame-clock rising edges. About 128 of them means quad speed. About 256 means normal or double speed. Any other count raises a ratio error.

A change on any select input restarts the dividers from zero, so the bit clock and frame clock keep a fixed phase relation after every reconfiguration.

Top module: `aclk_gen_top`

## Requirements
- R1: In master mode `mclkOut` is `hfClk` divided by 8 at normal speed and by 4 at double and quad speed, with a 50% duty cycle. Each bit-clock transition happens in the same cycle as a master-clock falling edge.
- R2: In master mode `bitClkOut` is `hfClk` divided by 32 at normal, 16 at double and 8 at quad speed, with a 50% duty cycle.
- R3: In master mode `frameOut` is `hfClk` divided by 2048, 1024 or 512 (64 bit-clock periods), with a 50% duty cycle. It changes level only in the cycle where `bitClkOut` falls.
- R4: In master mode the speed comes from the inputs. `dblSpeed`=1 selects double and takes priority. Otherwise `quadReq`=1 selects quad, and otherwise the speed is normal. `speedMode` reports 0 for normal, 1 for double and 2 for quad.
- R5: A change of `masterSel`, `dblSpeed` or `quadReq` is taken at the next rising edge of `hfClk`. After that edge all three clock outputs are low and their phase counts from zero.
- R6: In slave mode `mclkOut`, `bitClkOut` and `frameOut` are held low.
- R7: In slave mode, a window of 128±4 external master-clock rises between frame rises sets `quadDetected`=1 and `ratioErr`=0. With `dblSpeed`=0, `speedMode` then reads 2.
- R8: In slave mode, a window of 256±4 rises clears `quadDetected` and `ratioErr`. `speedMode` then reads 1 if `dblSpeed`=1 and 0 otherwise.
- R9: In slave mode, any other window count sets `ratioErr`=1 and `quadDetected`=0.
- R10: Nothing is judged at the first frame rise after reset or after entry into slave mode. In master mode both flags are cleared at the next clock edge. The flags change only after a frame rise.
- R11: While `rstN` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hfClk | input | 1 | High-frequency clock, the only clock of the block |
| rstN | input | 1 | Asynchronous reset, active low |
| masterSel | input | 1 | 1 = generate clocks, 0 = use external clocks |
| dblSpeed | input | 1 | Double-speed select |
| quadReq | input | 1 | Quad-speed select in master mode |
| extMclk | input | 1 | External master clock (slave mode) |
| extFrame | input | 1 | External frame clock (slave mode) |
| mclkOut | output | 1 | Generated master clock, low in slave mode |
| bitClkOut | output | 1 | Generated bit clock, low in slave mode |
| frameOut | output | 1 | Generated frame clock, low in slave mode |
| quadDetected | output | 1 | Slave mode: 128x master-clock ratio seen |
| ratioErr | output | 1 | Slave mode: ratio matches neither window |
| speedMode | output | 2 | 0 normal, 1 double, 2 quad |

## Verification
Two functions can fall in the same cycle. A frame-clock transition coincides with a bit-clock falling edge and a master-clock falling edge. A configuration change can also arrive on the very cycle a divider wraps. The bench switches speed directly from one master configuration to the next, at whatever phase the previous run left the dividers in. After every switch it restarts its arithmetic phase model at zero and compares all three clocks on every cycle against modulo-based expectations. In the detector, a master-clock rise and a frame rise arrive together, and the bench checks that this rise is counted into the new window.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  // Strobes from the control part to the divider datapath
  typedef struct packed {
    logic   restart;
    logic   drive;
    speed_e speed;
  } divCtl_t;

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterSel,
  input  logic       dblSpeed,
  input  logic       quadReq,
  input  logic       quadDetected,
  output divCtl_t    ctl,
  output logic [1:0] speedMode
);

  logic [2:0] cfgNow;
  logic [2:0] cfgPrev;
  logic       driveQ;
  speed_e     speedQ;
  speed_e     reqSpeed;
  speed_e     slaveSpeed;

  assign cfgNow = {masterSel, dblSpeed, quadReq};

  // R4: double has priority over quad
  always_comb begin
    if (dblSpeed)     reqSpeed = SPD_DOUBLE;
    else if (quadReq) reqSpeed = SPD_QUAD;
    else              reqSpeed = SPD_NORMAL;
  end

  always_comb begin
    if (dblSpeed)          slaveSpeed = SPD_DOUBLE;
    else if (quadDetected) slaveSpeed = SPD_QUAD;
    else                   slaveSpeed = SPD_NORMAL;
  end

  // Configuration is captured at the same edge that restarts the dividers (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPrev <= '0;
      driveQ  <= 1'b0;
      speedQ  <= SPD_NORMAL;
    end else begin
      cfgPrev <= cfgNow;
      driveQ  <= masterSel;
      speedQ  <= reqSpeed;
    end
  end

  always_comb begin
    ctl.restart = (cfgNow != cfgPrev);
    ctl.drive   = driveQ;
    ctl.speed   = speedQ;
  end

  assign speedMode = masterSel ? speedQ : slaveSpeed;

  // R4: reported speed code is always one of the three legal values
  a_r4_speed_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    speedMode != 2'd3);

endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
  import aclk_pkg::*;
#(
  parameter int FRAME_LOG2 = 11,  // hfClk cycles per frame at normal speed, log2
  parameter int BCLK_LOG2  = 6,   // bit clocks per frame, log2
  parameter int MCLK_LOG2  = 8    // master clocks per frame at normal/double, log2
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    mclkOut,
  output logic    bitClkOut,
  output logic    frameOut
);

  localparam int CNT_W    = FRAME_LOG2;
  localparam int N_SPEEDS = 3;

  logic [CNT_W-1:0] phaseCnt;
  logic [2:0]       taps [N_SPEEDS];
  logic [2:0]       selTap;

  // R5: restart or idle returns the phase to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         phaseCnt <= '0;
    else if (ctl.restart || !ctl.drive) phaseCnt <= '0;
    else                               phaseCnt <= phaseCnt + 1'b1;
  end

  // One tap set per speed: each halving of the frame length moves all taps
  // down one bit; quad runs its master clock at 128x instead of 256x.
  for (genvar s = 0; s < N_SPEEDS; s++) begin : g_tap
    localparam int FB = CNT_W - 1 - s;
    localparam int MB = FB - MCLK_LOG2 + ((s == 2) ? 1 : 0);
    localparam int BB = FB - BCLK_LOG2;
    assign taps[s] = {phaseCnt[MB], phaseCnt[BB], phaseCnt[FB]};
  end

  always_comb begin
    case (ctl.speed)
      SPD_NORMAL: selTap = taps[0];
      SPD_DOUBLE: selTap = taps[1];
      default:    selTap = taps[2];
    endcase
  end

  assign mclkOut   = ctl.drive & selTap[2];
  assign bitClkOut = ctl.drive & selTap[1];
  assign frameOut  = ctl.drive & selTap[0];

  // R3: frame edges only with a bit-clock falling edge
  a_r3_frame_on_bclk_fall: assert property (@(posedge clk) disable iff (!rstN)
    ((frameOut != $past(frameOut)) && !$past(ctl.restart))
      |-> ($past(bitClkOut) && !bitClkOut));

  // R1: bit-clock edges only with a master-clock falling edge
  a_r1_bclk_on_mclk_fall: assert property (@(posedge clk) disable iff (!rstN)
    ((bitClkOut != $past(bitClkOut)) && !$past(ctl.restart))
      |-> ($past(mclkOut) && !mclkOut));

  // R5: a restart leaves all clocks low in the following cycle
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.restart) |-> (!mclkOut && !bitClkOut && !frameOut));

endmodule

// File: rtl/aclk_rate_detect.sv
module aclk_rate_detect #(
  parameter int LO_RATIO = 128,
  parameter int HI_RATIO = 256,
  parameter int TOL      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic slaveEn,
  input  logic extMclk,
  input  logic extFrame,
  output logic quadDetected,
  output logic ratioErr
);

  localparam int CW = $clog2(HI_RATIO + TOL + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] QLO  = CW'(LO_RATIO - TOL);
  localparam logic [CW-1:0] QHI  = CW'(LO_RATIO + TOL);
  localparam logic [CW-1:0] NLO  = CW'(HI_RATIO - TOL);
  localparam logic [CW-1:0] NHI  = CW'(HI_RATIO + TOL);

  logic [1:0]    mSync, fSync;
  logic          mPrev, fPrev;
  logic          mRise, fRise;
  logic [CW-1:0] winCnt;
  logic          armed;
  logic          inQuad, inNorm;

  assign mRise  = mSync[1] & ~mPrev;
  assign fRise  = fSync[1] & ~fPrev;
  assign inQuad = (winCnt >= QLO) && (winCnt <= QHI);
  assign inNorm = (winCnt >= NLO) && (winCnt <= NHI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= '0; fSync <= '0; mPrev <= 1'b0; fPrev <= 1'b0;
      winCnt <= '0; armed <= 1'b0; quadDetected <= 1'b0; ratioErr <= 1'b0;
    end else if (!slaveEn) begin
      mSync <= '0; fSync <= '0; mPrev <= 1'b0; fPrev <= 1'b0;
      winCnt <= '0; armed <= 1'b0; quadDetected <= 1'b0; ratioErr <= 1'b0;
    end else begin
      mSync <= {mSync[0], extMclk};
      fSync <= {fSync[0], extFrame};
      mPrev <= mSync[1];
      fPrev <= fSync[1];
      if (fRise) begin
        armed  <= 1'b1;
        winCnt <= mRise ? CW'(1) : '0;   // a coincident rise opens the new window
        if (armed) begin                 // R10: first rise only arms
          quadDetected <= inQuad;
          ratioErr     <= !inQuad && !inNorm;
        end
      end else if (mRise && (winCnt != CMAX)) begin
        winCnt <= winCnt + 1'b1;
      end
    end
  end

  // R9: error and quad flags never together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(quadDetected && ratioErr));

  // R10: flags hold between frame rises
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(slaveEn) && slaveEn && !$past(fRise))
      |-> ($stable(quadDetected) && $stable(ratioErr)));

  // R10: leaving slave mode clears the flags
  a_r10_master_clear: assert property (@(posedge clk) disable iff (!rstN)
    !slaveEn |=> (!quadDetected && !ratioErr));

endmodule

// File: rtl/aclk_gen_top.sv
module aclk_gen_top
  import aclk_pkg::*;
#(
  parameter int FRAME_LOG2 = 11,
  parameter int BCLK_LOG2  = 6,
  parameter int MCLK_LOG2  = 8,
  parameter int LO_RATIO   = 128,
  parameter int HI_RATIO   = 256,
  parameter int RATIO_TOL  = 4
) (
  input  logic       hfClk,
  input  logic       rstN,
  input  logic       masterSel,
  input  logic       dblSpeed,
  input  logic       quadReq,
  input  logic       extMclk,
  input  logic       extFrame,
  output logic       mclkOut,
  output logic       bitClkOut,
  output logic       frameOut,
  output logic       quadDetected,
  output logic       ratioErr,
  output logic [1:0] speedMode
);

  divCtl_t divCtl;

  aclk_ctrl u_ctrl (
    .clk          (hfClk),
    .rstN         (rstN),
    .masterSel    (masterSel),
    .dblSpeed     (dblSpeed),
    .quadReq      (quadReq),
    .quadDetected (quadDetected),
    .ctl          (divCtl),
    .speedMode    (speedMode)
  );

  aclk_divider #(
    .FRAME_LOG2 (FRAME_LOG2),
    .BCLK_LOG2  (BCLK_LOG2),
    .MCLK_LOG2  (MCLK_LOG2)
  ) u_div (
    .clk       (hfClk),
    .rstN      (rstN),
    .ctl       (divCtl),
    .mclkOut   (mclkOut),
    .bitClkOut (bitClkOut),
    .frameOut  (frameOut)
  );

  aclk_rate_detect #(
    .LO_RATIO (LO_RATIO),
    .HI_RATIO (HI_RATIO),
    .TOL      (RATIO_TOL)
  ) u_det (
    .clk          (hfClk),
    .rstN         (rstN),
    .slaveEn      (!masterSel),
    .extMclk      (extMclk),
    .extFrame     (extFrame),
    .quadDetected (quadDetected),
    .ratioErr     (ratioErr)
  );

endmodule

// File: tb/sim_aclk_gen_top.sv
module sim_aclk_gen_top;

  localparam int CLK_PERIOD = 10;

  logic       hfClk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterSel = 1'b0;
  logic       dblSpeed = 1'b0;
  logic       quadReq = 1'b0;
  logic       extMclk = 1'b0;
  logic       extFrame = 1'b0;
  logic       mclkOut, bitClkOut, frameOut, quadDetected, ratioErr;
  logic [1:0] speedMode;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) hfClk = ~hfClk;

  aclk_gen_top u0 (
    .hfClk(hfClk), .rstN(rstN), .masterSel(masterSel), .dblSpeed(dblSpeed),
    .quadReq(quadReq), .extMclk(extMclk), .extFrame(extFrame),
    .mclkOut(mclkOut), .bitClkOut(bitClkOut), .frameOut(frameOut),
    .quadDetected(quadDetected), .ratioErr(ratioErr), .speedMode(speedMode)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  // Master run: config applied at a negedge, restart at the next posedge,
  // then phase k counts from zero at each following negedge.
  task automatic runMaster(input bit dbl, input bit quad, input int nCyc);
    int mDiv, bDiv, fDiv, expSpd;
    expSpd = dbl ? 1 : (quad ? 2 : 0);
    fDiv = (expSpd == 0) ? 2048 : (expSpd == 1) ? 1024 : 512;
    bDiv = fDiv / 64;
    mDiv = (expSpd == 0) ? 8 : 4;
    masterSel = 1'b1; dblSpeed = dbl; quadReq = quad;
    @(posedge hfClk);
    for (int k = 0; k < nCyc; k++) begin
      int expV;
      @(negedge hfClk);
      expV = (((k % mDiv) >= mDiv/2) ? 4 : 0) +
             (((k % bDiv) >= bDiv/2) ? 2 : 0) +
             (((k % fDiv) >= fDiv/2) ? 1 : 0);
      // R1 R2 R3 R5: all three clocks against the phase model
      check("R1/R2/R3/R5 clocks", {29'd0, mclkOut, bitClkOut, frameOut}, expV);
      if (k == 0) check("R4 speedMode", speedMode, expSpd);
    end
  endtask

  task automatic slaveFrames(input int ratio, input int nFr);
    for (int f = 0; f < nFr; f++) begin
      for (int m = 0; m < ratio; m++) begin
        @(negedge hfClk);
        extMclk = 1'b1; extFrame = (m < ratio/2);
        @(negedge hfClk);
        @(negedge hfClk);
        extMclk = 1'b0;
        @(negedge hfClk);
      end
    end
    repeat (10) @(negedge hfClk);
  endtask

  initial begin
    repeat (200000) @(posedge hfClk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge hfClk);
    // R11: reset state
    check("R11 mclk", mclkOut, 0);
    check("R11 bclk", bitClkOut, 0);
    check("R11 frame", frameOut, 0);
    check("R11 flags", {quadDetected, ratioErr}, 0);
    check("R11 speedMode", speedMode, 0);
    rstN = 1'b1;
    repeat (3) @(negedge hfClk);

    // R10: a single frame only arms the detector
    slaveFrames(128, 1);
    check("R10 first rise quad", quadDetected, 0);
    check("R10 first rise err", ratioErr, 0);
    slaveFrames(128, 2);
    check("R7 quad flag", quadDetected, 1);
    check("R7 err flag", ratioErr, 0);
    check("R7 speedMode", speedMode, 2);
    // R6: outputs stay low in slave mode
    check("R6 slave clocks low", {mclkOut, bitClkOut, frameOut}, 0);

    slaveFrames(256, 3);
    check("R8 quad flag", quadDetected, 0);
    check("R8 err flag", ratioErr, 0);
    check("R8 speedMode normal", speedMode, 0);
    dblSpeed = 1'b1;
    @(negedge hfClk);
    check("R8 speedMode double", speedMode, 1);
    dblSpeed = 1'b0;
    @(negedge hfClk);

    slaveFrames(131, 3);
    check("R7 tolerance quad", quadDetected, 1);
    slaveFrames(200, 3);
    check("R9 err flag", ratioErr, 1);
    check("R9 quad flag", quadDetected, 0);
    check("R9 speedMode", speedMode, 0);
    slaveFrames(252, 3);
    check("R8 tolerance err", ratioErr, 0);
    check("R8 tolerance quad", quadDetected, 0);
    slaveFrames(128, 3);
    check("R7 quad again", quadDetected, 1);

    // Master sweep, each change taken straight from the previous phase
    runMaster(1'b0, 1'b0, 2 * 2048 + 5);
    check("R10 flags cleared in master", {quadDetected, ratioErr}, 0);
    runMaster(1'b1, 1'b0, 2 * 1024 + 7);
    runMaster(1'b0, 1'b1, 2 * 512 + 3);
    runMaster(1'b1, 1'b1, 2 * 1024 + 1);   // R4: double wins over quad
    runMaster(1'b0, 1'b0, 1000);           // R5: restart mid-frame

    masterSel = 1'b0; dblSpeed = 1'b0; quadReq = 1'b0;
    @(negedge hfClk);
    check("R6 back to slave low", {mclkOut, bitClkOut, frameOut}, 0);
    repeat (40) begin
      @(negedge hfClk);
      check("R6 slave hold low", {mclkOut, bitClkOut, frameOut}, 0);
    end

    done = 1'b1;
    summary();
  end

endmodule